// File: doc/BRIEF.md
# ChaCha20 Iterative Block Function Core

This core computes the ChaCha20 block function over a 512-bit state held as sixteen 32-bit words. A load strobe captures the sixteen input words into an initial-state register. A double-round datapath, made of a registered column round followed by a registered diagonal round, then iterates on the working state. An external select line chooses where that datapath gets its input. The block does not sequence the rounds itself. The caller holds the select high for the two cycles after the load so that the captured state enters the datapath. The caller then drives it low so that the round register feeds back.

An internal edge counter triggers the final step at a fixed point in the schedule. The counter does not sequence the rounds. At that point the core adds the initial state to the working state word by word, modulo 2^32, and registers the sixteen result words. The result register holds its value until the next result is produced. Typical use places the core behind a keystream controller. That controller supplies the constants, key, block counter and nonce in the standard word positions, and it consumes the output words as keystream.

Top module: `chacha_block_core`

## Requirements
- R1: On a clock edge where `load` is high, input word k (bits [32k+31:32k] of `state_in`) is captured into state position k of the initial-state register. On every other edge that register keeps its value.
- R2: Each quarter-round on (a,b,c,d) performs, in order: a+=b, d^=a, d<<<=16; c+=d, b^=c, b<<<=12; a+=b, d^=a, d<<<=8; c+=d, b^=c, b<<<=7. A double round applies it to the columns (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15) and then to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14).
- R3: Let the load edge be edge 0. With `use_init` high for edges 1 and 2 and low afterwards, the output after edge 21 equals the word-wise modulo-2^32 sum of the initial state and the state after ten double rounds.
- R4: Output word k appears at bits [32k+31:32k] of `state_out`. The output changes only on the completion edge, which is 2*DOUBLE_ROUNDS+1 edges after a load. Between completions, changes on `state_in`, `use_init` or a load in progress leave it unchanged.
- R5: A synchronous active-high `rst` clears the initial-state, pipeline, round and output registers to zero.
- R6: With constants 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574 and key bytes 0x00..0x1f, the following inputs give the following first output words. Counter 1 with nonce 0x09000000, 0x4a000000, 0x00000000 gives 0xe4e7f110 (word 15 is 0x4e3c50a2). Counter 1 with nonce 0x00000000, 0x4a000000, 0x00000000 gives 0xf3514f22. Counter 2 with that same nonce gives 0x9f74a669.
- R7: A load during a computation abandons it and restarts the schedule from the new load edge. The output then delivers only the result of the newly loaded block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `state_in` into the initial-state register |
| use_init | input | 1 | High: double round reads the initial state; low: reads the round register |
| state_in | input | 512 | Sixteen 32-bit input words, word k at bits [32k+31:32k] |
| state_out | output | 512 | Sixteen 32-bit result words, word k at bits [32k+31:32k] |

## Verification
The bench builds the core with its default of ten double rounds. This makes the standard test vectors, and all sixteen words of each result, directly comparable with a behavioural model in the bench. Under that setting the completion edge lands exactly 21 edges after the load. The bench can therefore probe the output one edge early, to confirm that the previous result is still held, and probe it again after the result, with the inputs disturbed. An abandoned computation followed by a fresh load shows whether the schedule restarts cleanly from the second load.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

   localparam int WORD_W   = 32;
   localparam int N_WORDS  = 16;
   localparam int N_QR     = 4;

   localparam int ROT_A = 16;
   localparam int ROT_B = 12;
   localparam int ROT_C = 8;
   localparam int ROT_D = 7;

   typedef logic [WORD_W-1:0]          word_t;
   typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

   function automatic word_t rotl(input word_t v, input int unsigned n);
      rotl = (v << n) | (v >> (WORD_W - n));
   endfunction

   // Lane selection for quarter-round q; diagonal rounds shift each row by its index.
   function automatic int lane_idx(input int q, input int row, input bit diag);
      lane_idx = 4 * row + ((q + (diag ? row : 0)) % 4);
   endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
   import chacha_pkg::*;
(
   input  word_t a_i,
   input  word_t b_i,
   input  word_t c_i,
   input  word_t d_i,
   output word_t a_o,
   output word_t b_o,
   output word_t c_o,
   output word_t d_o
);

   word_t a1, b1, c1, d1;
   word_t a2, b2, c2, d2;

   always_comb begin
      a1 = a_i + b_i;
      d1 = rotl(d_i ^ a1, ROT_A);
      c1 = c_i + d1;
      b1 = rotl(b_i ^ c1, ROT_B);
      a2 = a1 + b1;
      d2 = rotl(d1 ^ a2, ROT_C);
      c2 = c1 + d2;
      b2 = rotl(b1 ^ c2, ROT_D);
   end

   assign a_o = a2;
   assign b_o = b2;
   assign c_o = c2;
   assign d_o = d2;

endmodule

// File: rtl/chacha_half_round.sv
module chacha_half_round
   import chacha_pkg::*;
#(
   parameter bit DIAG = 1'b0
)(
   input  state_t st_i,
   output state_t st_o
);

   word_t qa [N_QR];
   word_t qb [N_QR];
   word_t qc [N_QR];
   word_t qd [N_QR];

   for (genvar q = 0; q < N_QR; q++) begin : g_qr
      localparam int IA = lane_idx(q, 0, DIAG);
      localparam int IB = lane_idx(q, 1, DIAG);
      localparam int IC = lane_idx(q, 2, DIAG);
      localparam int ID = lane_idx(q, 3, DIAG);

      chacha_qr u_qr (
         .a_i (st_i[IA]),
         .b_i (st_i[IB]),
         .c_i (st_i[IC]),
         .d_i (st_i[ID]),
         .a_o (qa[q]),
         .b_o (qb[q]),
         .c_o (qc[q]),
         .d_o (qd[q])
      );
   end

   always_comb begin
      st_o = '0;
      for (int q = 0; q < N_QR; q++) begin
         st_o[lane_idx(q, 0, DIAG)] = qa[q];
         st_o[lane_idx(q, 1, DIAG)] = qb[q];
         st_o[lane_idx(q, 2, DIAG)] = qc[q];
         st_o[lane_idx(q, 3, DIAG)] = qd[q];
      end
   end

endmodule

// File: rtl/chacha_feedfwd.sv
module chacha_feedfwd
   import chacha_pkg::*;
(
   input  state_t init_i,
   input  state_t work_i,
   output state_t sum_o
);

   for (genvar w = 0; w < N_WORDS; w++) begin : g_add
      assign sum_o[w] = init_i[w] + work_i[w];
   end

endmodule

// File: rtl/chacha_block_core.sv
module chacha_block_core
   import chacha_pkg::*;
#(
   parameter int DOUBLE_ROUNDS = 10,
   parameter int STATE_BITS    = 512
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic                  use_init,
   input  logic [STATE_BITS-1:0] state_in,
   output logic [STATE_BITS-1:0] state_out
);

   localparam int LAT  = 2 * DOUBLE_ROUNDS + 1;
   localparam int CW   = $clog2(LAT + 1);
   localparam logic [CW-1:0] CNT_IDLE = CW'(LAT);
   localparam logic [CW-1:0] CNT_FIN  = CW'(LAT - 1);

   initial begin
      if (DOUBLE_ROUNDS < 1)
         $error("chacha_block_core: DOUBLE_ROUNDS must be at least 1");
      if (STATE_BITS != N_WORDS * WORD_W)
         $error("chacha_block_core: STATE_BITS must equal %0d", N_WORDS * WORD_W);
   end

   state_t init_q;
   state_t stage_q;
   state_t round_q;
   state_t out_q;
   logic [CW-1:0] cnt_q;

   state_t dr_src;
   state_t col_res;
   state_t diag_res;
   state_t sum_res;

   assign dr_src = use_init ? init_q : round_q;

   chacha_half_round #(.DIAG(1'b0)) u_col (
      .st_i (dr_src),
      .st_o (col_res)
   );

   chacha_half_round #(.DIAG(1'b1)) u_diag (
      .st_i (stage_q),
      .st_o (diag_res)
   );

   chacha_feedfwd u_ff (
      .init_i (init_q),
      .work_i (round_q),
      .sum_o  (sum_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         init_q <= '0;
      end else if (load) begin
         init_q <= state_t'(state_in);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
         round_q <= '0;
      end else begin
         stage_q <= col_res;
         round_q <= diag_res;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= CNT_IDLE;
      end else if (load) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_IDLE) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= '0;
      end else if (!load && cnt_q == CNT_FIN) begin
         out_q <= sum_res;
      end
   end

   assign state_out = STATE_BITS'(out_q);

endmodule

// File: rtl/chacha_block_chk.sv
module chacha_block_chk
   import chacha_pkg::*;
#(
   parameter int DOUBLE_ROUNDS = 10,
   parameter int STATE_BITS    = 512
)(
   input logic                  clk,
   input logic                  rst,
   input logic                  load,
   input logic [STATE_BITS-1:0] state_in,
   input state_t                init_q,
   input logic [STATE_BITS-1:0] state_out
);

   localparam int LAT = 2 * DOUBLE_ROUNDS + 1;
   localparam int CW  = $clog2(LAT + 1);

   logic [CW-1:0] ck_q = CW'(LAT);
   logic          rst_seen = 1'b0;

   always_ff @(posedge clk) begin
      rst_seen <= rst;
      if (rst)                    ck_q <= CW'(LAT);
      else if (load)              ck_q <= '0;
      else if (ck_q != CW'(LAT))  ck_q <= ck_q + 1'b1;
   end

   // R5: one edge after reset the result register reads zero
   always @(posedge clk) begin
      if (rst_seen) begin
         p_reset_clear_r5: assert (state_out == '0);
      end
   end

   // R1: a load edge captures the input words
   p_capture_r1: assert property (@(posedge clk) disable iff (rst)
      load |=> (init_q == state_t'($past(state_in))));

   // R1: without a load the initial state is kept
   p_init_keep_r1: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(init_q));

   // R4: the result only moves on the completion edge
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !(ck_q == CW'(LAT - 1) && !load) |=> $stable(state_out));

endmodule

bind chacha_block_core chacha_block_chk #(
   .DOUBLE_ROUNDS (DOUBLE_ROUNDS),
   .STATE_BITS    (STATE_BITS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .load      (load),
   .state_in  (state_in),
   .init_q    (init_q),
   .state_out (state_out)
);

// File: tb/chacha_block_core_tb_top.sv
module chacha_block_core_tb_top;
   import chacha_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DR         = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic         use_init = 1'b0;
   logic [511:0] state_in = '0;
   logic [511:0] state_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chacha_block_core #(.DOUBLE_ROUNDS(DR)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .use_init  (use_init),
      .state_in  (state_in),
      .state_out (state_out)
   );

   typedef struct {
      int     req;
      state_t exp;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     chk_ev;

   // ---------------- behavioural model ----------------
   function automatic word_t m_rotl(word_t v, int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   function automatic void m_qr(ref word_t x[16], input int a, int b, int c, int d);
      x[a] = x[a] + x[b]; x[d] = m_rotl(x[d] ^ x[a], 16);
      x[c] = x[c] + x[d]; x[b] = m_rotl(x[b] ^ x[c], 12);
      x[a] = x[a] + x[b]; x[d] = m_rotl(x[d] ^ x[a], 8);
      x[c] = x[c] + x[d]; x[b] = m_rotl(x[b] ^ x[c], 7);
   endfunction

   function automatic state_t m_block(state_t s);
      word_t  x[16];
      state_t r;
      for (int i = 0; i < 16; i++) x[i] = s[i];
      for (int k = 0; k < DR; k++) begin
         m_qr(x, 0, 4,  8, 12); m_qr(x, 1, 5,  9, 13);
         m_qr(x, 2, 6, 10, 14); m_qr(x, 3, 7, 11, 15);
         m_qr(x, 0, 5, 10, 15); m_qr(x, 1, 6, 11, 12);
         m_qr(x, 2, 7,  8, 13); m_qr(x, 3, 4,  9, 14);
      end
      for (int i = 0; i < 16; i++) r[i] = x[i] + s[i];
      return r;
   endfunction

   function automatic state_t mk_state(word_t ctr, word_t n0, word_t n1, word_t n2);
      state_t s;
      s[0] = 32'h61707865; s[1] = 32'h3320646e;
      s[2] = 32'h79622d32; s[3] = 32'h6b206574;
      for (int k = 0; k < 8; k++)
         s[4+k] = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
      s[12] = ctr; s[13] = n0; s[14] = n1; s[15] = n2;
      return s;
   endfunction

   // ---------------- check helpers ----------------
   task automatic check_word(int req, string what, word_t act, word_t exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   task automatic push_and_fire(int req, state_t exp);
      sb_item_t it;
      it.req = req;
      it.exp = exp;
      sb_q.push_back(it);
      -> chk_ev;
      #1;
   endtask

   // Monitor: pops expected items and compares all sixteen words
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            state_t   act;
            it  = sb_q.pop_front();
            act = state_t'(state_out);
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               for (int w = 0; w < 16; w++)
                  if (act[w] !== it.exp[w])
                     $display("FAIL R%0d word %0d: actual %08h expected %08h",
                              it.req, w, act[w], it.exp[w]);
            end
         end
      end
   end

   // Driver: load edge, two select-high edges, then select low until completion.
   // R3 schedule: result visible after edge 21 counted from the load edge.
   task automatic run_block(state_t s, int req, bit have_prev, state_t prev);
      @(negedge clk); state_in = 512'(s); load = 1'b1; use_init = 1'b0;
      @(negedge clk); load = 1'b0; use_init = 1'b1;
      repeat (2) @(negedge clk);
      use_init = 1'b0;
      repeat (18) @(negedge clk);
      if (have_prev) push_and_fire(4, prev); // R4: previous result still held after edge 20
      @(negedge clk);
      push_and_fire(req, m_block(s));
   endtask

   state_t s_a, s_b, s_c, s_d, s_e;
   state_t got;

   initial begin
      s_a = mk_state(32'd1, 32'h09000000, 32'h4a000000, 32'h0);
      s_b = mk_state(32'd1, 32'h0,        32'h4a000000, 32'h0);
      s_c = mk_state(32'd2, 32'h0,        32'h4a000000, 32'h0);
      for (int i = 0; i < 16; i++) s_d[i] = $urandom;
      for (int i = 0; i < 16; i++) s_e[i] = $urandom;

      // model sanity against fixed words (R6)
      got = m_block(s_a);
      check_word(6, "model vec1 word0",  got[0],  32'he4e7f110);
      check_word(6, "model vec1 word15", got[15], 32'h4e3c50a2);

      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R5: reset state of the result
      push_and_fire(5, '0);

      // R2 R3 R6: first standard vector
      run_block(s_a, 3, 1'b0, '0);
      check_word(6, "vec1 word0",  state_out[31:0],    32'he4e7f110);
      check_word(6, "vec1 word15", state_out[511:480], 32'h4e3c50a2);

      // R4: disturb inputs without load; result must hold
      @(negedge clk); state_in = ~state_in; use_init = 1'b1;
      repeat (3) @(negedge clk); use_init = 1'b0;
      repeat (3) @(negedge clk);
      push_and_fire(4, m_block(s_a));

      // R6: counter 1 and counter 2, with mid-run hold check (R4)
      run_block(s_b, 6, 1'b1, m_block(s_a));
      check_word(6, "ctr1 word0", state_out[31:0], 32'hf3514f22);
      run_block(s_c, 6, 1'b1, m_block(s_b));
      check_word(6, "ctr2 word0", state_out[31:0], 32'h9f74a669);

      // R1 R2: arbitrary word pattern, all positions checked
      run_block(s_d, 1, 1'b1, m_block(s_c));

      // R7: abandon a block part way, reload another
      @(negedge clk); state_in = 512'(s_a); load = 1'b1; use_init = 1'b0;
      @(negedge clk); load = 1'b0; use_init = 1'b1;
      repeat (2) @(negedge clk); use_init = 1'b0;
      repeat (5) @(negedge clk);
      run_block(s_e, 7, 1'b1, m_block(s_d));

      // R5: reset after a result clears the output
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      push_and_fire(5, '0);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule